// File: doc/BRIEF.md
# Synchronized Sine-Fit Response Analyzer

This block grades a converter channel under self-test. It runs at the decimated output rate and receives two signed sample streams that share one valid strobe. The first stream is the converter's response to a periodic binary stimulus. The second is a reference sinusoid that the idle channel's decimator makes from the same stimulus, so it already has the same frequency and phase as the response. Because the two streams are aligned, only offset and amplitude are fitted. Phase and frequency are never estimated.

The stimulus is periodic, so no samples are stored. After a start command the analyzer makes two passes, and each pass begins on a window-sync pulse. The first pass sums the response samples and the products of response and reference. A short compute phase then turns these sums into a DC estimate, an amplitude estimate, a fitted gain and a signal power. The second pass rebuilds the fitted reference sample by sample and adds up the squared error. All of this work goes through one multiplier. A pass/fail flag compares the signal power against a window and the error power against a ceiling, so no logarithm is needed. The scaling constants come in as inputs with FB fractional bits: the reciprocal window length (about 2^FB/N) and the reciprocal reference amplitude.

Top module: `sinefit_analyzer`

## Requirements
- R1: After reset, busy, done, pass and ovf are 0, and dc_est, amp_est, sig_pow and err_pow are 0.
- R2: A start seen while idle clears done, pass, ovf and all four results, and busy is 1 on the next cycle. A start seen while busy is ignored and does not change the outcome of the run in progress.
- R3: Pass one begins with the first valid sample whose win_sync is 1. Valid samples that come earlier are ignored, and so are samples that arrive during the compute phase.
- R4: dc_est = floor(So·inv_len / 2^FB), where So is the sum of the N response samples of pass one.
- R5: amp_est = floor(floor(Sp·inv_len / 2^FB)·inv_ref_amp / 2^(FB-1)), where Sp is the sum over pass one of response×reference. This is twice the correlation mean divided by the reference amplitude.
- R6: sig_pow = floor(amp_est² / 2).
- R7: Pass two begins at the next valid sample with win_sync = 1 after the compute phase. With gain g = amp_est·inv_ref_amp, each fitted sample is floor(g·ref / 2^FB) + dc_est, and err_pow is the sum over N samples of (response − fitted)². During pass two, valid samples must be at least 2 cycles apart.
- R8: Accumulators saturate at the signed AW-bit limits instead of wrapping. Any saturation sets ovf, and ovf stays set until the next accepted start.
- R9: On completion, pass = 1 exactly when ovf = 0, sig_min ≤ sig_pow ≤ sig_max and err_pow ≤ err_max (all compared as signed values).
- R10: done rises when pass two ends. done and all results then hold steady, whatever samples arrive, until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a measurement (taken only while idle) |
| smp_valid | input | 1 | Both sample inputs carry a new sample |
| win_sync | input | 1 | Marks the first sample of a stimulus window |
| smp_out | input | DW | Converter response sample, signed |
| smp_ref | input | DW | Aligned reference sample, signed |
| inv_len | input | CW | Reciprocal of window length, unsigned, FB fractional bits |
| inv_ref_amp | input | CW | Reciprocal of reference amplitude, unsigned, FB fractional bits |
| sig_min | input | AW | Lower signal-power limit, signed |
| sig_max | input | AW | Upper signal-power limit, signed |
| err_max | input | AW | Error-power ceiling, signed |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | Results valid |
| dc_est | output | AW | Offset estimate |
| amp_est | output | AW | Amplitude estimate |
| sig_pow | output | AW | Signal power estimate |
| err_pow | output | AW | Noise-plus-distortion power |
| ovf | output | 1 | Sticky saturation flag |
| pass | output | 1 | Verdict against the limits |

## Verification
Before each window sync the bench sends large junk samples. A design that opened pass one on any valid sample, rather than on the sync, would give the wrong offset and amplitude. One vector inverts the response, so the amplitude is negative; a sign slip in the gain or in the signal power would show up there. Other vectors fail only the error ceiling or only the signal window, which separates the terms of the verdict. A second instance with narrow accumulators is driven with full-scale samples so that saturation and the sticky flag are forced: a wrapping sum would clear ovf and could let pass through. A stray start during a run and extra samples after completion catch designs that restart or keep accumulating.

// File: rtl/sinefit_analyzer.sv
module sinefit_analyzer #(
  parameter int N  = 563,
  parameter int DW = 16,
  parameter int CW = 24,
  parameter int FB = 20,
  parameter int AW = 48
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 smp_valid,
  input  logic                 win_sync,
  input  logic signed [DW-1:0] smp_out,
  input  logic signed [DW-1:0] smp_ref,
  input  logic [CW-1:0]        inv_len,
  input  logic [CW-1:0]        inv_ref_amp,
  input  logic signed [AW-1:0] sig_min,
  input  logic signed [AW-1:0] sig_max,
  input  logic signed [AW-1:0] err_max,
  output logic                 busy,
  output logic                 done,
  output logic signed [AW-1:0] dc_est,
  output logic signed [AW-1:0] amp_est,
  output logic signed [AW-1:0] sig_pow,
  output logic signed [AW-1:0] err_pow,
  output logic                 ovf,
  output logic                 pass
);

  localparam int CNTW = $clog2(N + 1);
  localparam int PW   = 2 * AW;

  typedef enum logic [2:0] {S_IDLE, S_WAIT1, S_ACC1, S_CALC, S_WAIT2, S_ACC2, S_FIN} st_t;

  st_t                  state;
  logic [CNTW-1:0]      cnt;
  logic [2:0]           step;
  logic                 sub;
  logic signed [AW-1:0] sum_o, sum_p, gain, fit, xo;
  logic signed [AW-1:0] ma, mb;
  logic signed [PW-1:0] prod, sh_fb, sh_fb1, sh_1;

  function automatic logic [AW:0] acc_add(input logic signed [AW-1:0] a,
                                          input logic signed [PW-1:0] b);
    logic signed [PW:0] s;
    s = {{(AW+1){a[AW-1]}}, a} + {b[PW-1], b};
    if (s[PW:AW-1] == '0 || s[PW:AW-1] == '1)
      return {1'b0, s[AW-1:0]};
    else if (s[PW])
      return {1'b1, 1'b1, {(AW-1){1'b0}}};
    else
      return {1'b1, 1'b0, {(AW-1){1'b1}}};
  endfunction

  wire signed [AW-1:0] o_x  = {{(AW-DW){smp_out[DW-1]}}, smp_out};
  wire signed [AW-1:0] r_x  = {{(AW-DW){smp_ref[DW-1]}}, smp_ref};
  wire signed [AW-1:0] c_n  = {{(AW-CW){1'b0}}, inv_len};
  wire signed [AW-1:0] c_a  = {{(AW-CW){1'b0}}, inv_ref_amp};
  wire signed [AW-1:0] err  = xo - fit;
  wire signed [PW-1:0] o_w  = {{AW{o_x[AW-1]}}, o_x};

  wire take1 = smp_valid && ((state == S_WAIT1 && win_sync) || state == S_ACC1);
  wire take2 = smp_valid && ((state == S_WAIT2 && win_sync) || (state == S_ACC2 && !sub));
  wire last  = (cnt == CNTW'(N - 1));

  always_comb begin
    ma = '0;
    mb = '0;
    case (state)
      S_WAIT1, S_ACC1: begin ma = o_x; mb = r_x; end
      S_CALC: begin
        case (step)
          3'd0:    begin ma = sum_o;   mb = c_n;     end
          3'd1:    begin ma = sum_p;   mb = c_n;     end
          3'd2,
          3'd3:    begin ma = amp_est; mb = c_a;     end
          default: begin ma = amp_est; mb = amp_est; end
        endcase
      end
      S_WAIT2, S_ACC2: begin
        if (sub) begin ma = err;  mb = err; end
        else     begin ma = gain; mb = r_x; end
      end
      default: ;
    endcase
  end

  assign prod   = ma * mb;
  assign sh_fb  = prod >>> FB;
  assign sh_fb1 = prod >>> (FB - 1);
  assign sh_1   = prod >>> 1;
  assign busy   = (state != S_IDLE);

  wire [AW:0] r_o = acc_add(sum_o, o_w);
  wire [AW:0] r_p = acc_add(sum_p, prod);
  wire [AW:0] r_e = acc_add(err_pow, prod);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt <= '0; step <= '0; sub <= 1'b0;
      sum_o <= '0; sum_p <= '0; gain <= '0; fit <= '0; xo <= '0;
      dc_est <= '0; amp_est <= '0; sig_pow <= '0; err_pow <= '0;
      ovf <= 1'b0; pass <= 1'b0; done <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          cnt <= '0; step <= '0; sub <= 1'b0;
          sum_o <= '0; sum_p <= '0; gain <= '0;
          dc_est <= '0; amp_est <= '0; sig_pow <= '0; err_pow <= '0;
          ovf <= 1'b0; pass <= 1'b0; done <= 1'b0;
          state <= S_WAIT1;
        end
        S_WAIT1, S_ACC1: if (take1) begin
          sum_o <= r_o[AW-1:0];
          sum_p <= r_p[AW-1:0];
          ovf   <= ovf | r_o[AW] | r_p[AW];
          if (last) begin
            cnt <= '0; step <= '0; state <= S_CALC;
          end else begin
            cnt <= cnt + 1'b1; state <= S_ACC1;
          end
        end
        S_CALC: begin
          step <= step + 1'b1;
          case (step)
            3'd0: dc_est  <= sh_fb[AW-1:0];
            3'd1: amp_est <= sh_fb[AW-1:0];
            3'd2: amp_est <= sh_fb1[AW-1:0];
            3'd3: gain    <= prod[AW-1:0];
            default: begin
              sig_pow <= sh_1[AW-1:0];
              state   <= S_WAIT2;
            end
          endcase
        end
        S_WAIT2, S_ACC2: begin
          if (state == S_ACC2 && sub) begin
            err_pow <= r_e[AW-1:0];
            ovf     <= ovf | r_e[AW];
            sub     <= 1'b0;
            if (last) state <= S_FIN;
            else      cnt <= cnt + 1'b1;
          end else if (take2) begin
            fit   <= sh_fb[AW-1:0] + dc_est;
            xo    <= o_x;
            sub   <= 1'b1;
            state <= S_ACC2;
          end
        end
        S_FIN: begin
          pass  <= !ovf && (sig_pow >= sig_min) && (sig_pow <= sig_max) && (err_pow <= err_max);
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sinefit_analyzer_sva.sv
module sinefit_analyzer_sva #(
  parameter int AW = 48
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic                 pass,
  input logic                 ovf,
  input logic signed [AW-1:0] sig_pow,
  input logic signed [AW-1:0] err_pow
);

  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done && !pass && !ovf));

  a_r2_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  a_r7_err_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
    !err_pow[AW-1]);

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(start && !busy)) |=> ovf);

  a_r9_pass_clean: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> (!ovf && done));

  a_r10_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  a_r10_results_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> ($stable(err_pow) && $stable(sig_pow)));

endmodule

bind sinefit_analyzer sinefit_analyzer_sva #(.AW(AW)) u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .pass(pass), .ovf(ovf), .sig_pow(sig_pow), .err_pow(err_pow)
);

// File: tb/sinefit_analyzer_test.sv
module sinefit_analyzer_test;
  localparam int CLK_P = 10;
  localparam int N = 8, DW = 16, CW = 24, FB = 20, AW = 48, AWS = 32;
  localparam longint BIG = 64'd1 << 40;
  localparam int S8[8] = '{0, 7, 10, 7, 0, -7, -10, -7};
  localparam int NZ[8] = '{1, -2, 0, 3, -1, 2, -3, 0};

  typedef struct packed {
    int a; int g; int d; int k;
    longint emax; longint slo; longint shi;
  } vec_t;

  localparam vec_t VEC[5] = '{
    '{100,  8,    0,  0, BIG, 0,   BIG},
    '{200,  4, -300,  5, BIG, 0,   BIG},
    '{ 50, 12, 1000, 40, 0,   0,   BIG},
    '{300,  6,   50,  2, BIG, BIG, BIG},
    '{ 10, -8,   -5,  1, BIG, 0,   BIG}
  };

  logic clk = 0, rst_n = 0, start = 0, smp_valid = 0, win_sync = 0;
  logic signed [DW-1:0] smp_out = 0, smp_ref = 0;
  logic [CW-1:0] inv_len = CW'((1 << FB) / N), inv_ref_amp = 0;
  logic signed [AW-1:0] sig_min = 0, sig_max = 0, err_max = 0;
  logic busy, done, ovf, pass;
  logic signed [AW-1:0] dc_est, amp_est, sig_pow, err_pow;
  logic busy_s, done_s, ovf_s, pass_s;
  logic signed [AWS-1:0] dc_s, amp_s, sig_s, err_s;

  int checks = 0, fails = 0;
  longint e_dc, e_amp, e_sig, e_err;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  sinefit_analyzer #(.N(N), .DW(DW), .CW(CW), .FB(FB), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .smp_valid(smp_valid), .win_sync(win_sync),
    .smp_out(smp_out), .smp_ref(smp_ref), .inv_len(inv_len), .inv_ref_amp(inv_ref_amp),
    .sig_min(sig_min), .sig_max(sig_max), .err_max(err_max),
    .busy(busy), .done(done), .dc_est(dc_est), .amp_est(amp_est),
    .sig_pow(sig_pow), .err_pow(err_pow), .ovf(ovf), .pass(pass));

  sinefit_analyzer #(.N(N), .DW(DW), .CW(CW), .FB(FB), .AW(AWS)) uut_sat (
    .clk(clk), .rst_n(rst_n), .start(start), .smp_valid(smp_valid), .win_sync(win_sync),
    .smp_out(smp_out), .smp_ref(smp_ref), .inv_len(inv_len), .inv_ref_amp(inv_ref_amp),
    .sig_min('0), .sig_max({1'b0, {(AWS-1){1'b1}}}), .err_max({1'b0, {(AWS-1){1'b1}}}),
    .busy(busy_s), .done(done_s), .dc_est(dc_s), .amp_est(amp_s),
    .sig_pow(sig_s), .err_pow(err_s), .ovf(ovf_s), .pass(pass_s));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int resp(input int a, input int g, input int d, input int k, input int i);
    return ((a * S8[i] * g) >>> 3) + d + k * NZ[i];
  endfunction

  task automatic model(input int a, input int g, input int d, input int k, input longint inva);
    longint so = 0, sp = 0, t, gn, ft, e;
    e_err = 0;
    for (int i = 0; i < N; i++) begin
      so += resp(a, g, d, k, i);
      sp += longint'(resp(a, g, d, k, i)) * (a * S8[i]);
    end
    e_dc  = (so * longint'(inv_len)) >>> FB;
    t     = (sp * longint'(inv_len)) >>> FB;
    e_amp = (t * inva) >>> (FB - 1);
    e_sig = (e_amp * e_amp) >>> 1;
    gn    = e_amp * inva;
    for (int i = 0; i < N; i++) begin
      ft = ((gn * (a * S8[i])) >>> FB) + e_dc;
      e = resp(a, g, d, k, i) - ft;
      e_err += e * e;
    end
  endtask

  task automatic send(input int o, input int r, input bit s);
    @(negedge clk);
    smp_valid = 1; win_sync = s; smp_out = DW'(o); smp_ref = DW'(r);
    @(negedge clk);
    smp_valid = 0; win_sync = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_start;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  // R3: junk before the first sync must not enter the sums
  task automatic feed(input int a, input int g, input int d, input int k, input bit stray);
    bit stop = 0;
    for (int j = 0; j < 3; j++) send(30000, -30000, 0);
    for (int p = 0; p < 8 && !stop; p++)
      for (int i = 0; i < N && !stop; i++) begin
        send(resp(a, g, d, k, i), a * S8[i], i == 0);
        if (stray && p == 0 && i == 3) pulse_start;
        if (done) stop = 1;
      end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !pass && !ovf, "R1 flags", {busy, done, pass, ovf}, 0);
    chk(dc_est == 0 && amp_est == 0 && sig_pow == 0 && err_pow == 0, "R1 results", err_pow, 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < 5; v++) begin
      longint inva = (longint'(1) << FB) / (10 * VEC[v].a);
      bit exp_pass;
      inv_ref_amp = CW'(inva);
      sig_min = AW'(VEC[v].slo); sig_max = AW'(VEC[v].shi); err_max = AW'(VEC[v].emax);
      model(VEC[v].a, VEC[v].g, VEC[v].d, VEC[v].k, inva);
      exp_pass = (e_sig >= VEC[v].slo) && (e_sig <= VEC[v].shi) && (e_err <= VEC[v].emax);
      pulse_start;
      chk(busy && !done, "R2 busy after start", busy, 1);
      feed(VEC[v].a, VEC[v].g, VEC[v].d, VEC[v].k, v == 0);
      repeat (4) @(negedge clk);
      chk(done == 1, "R10 done", done, 1);
      chk(dc_est == AW'(e_dc), "R4 dc", dc_est, e_dc);
      chk(amp_est == AW'(e_amp), "R5 amp", amp_est, e_amp);
      chk(sig_pow == AW'(e_sig), "R6 sig", sig_pow, e_sig);
      chk(err_pow == AW'(e_err), "R7 err", err_pow, e_err);
      chk(pass == exp_pass && !ovf, "R9 pass", pass, exp_pass);
    end

    // R10: extra samples after completion change nothing
    for (int i = 0; i < N; i++) send(20000, 123, i == 0);
    chk(done == 1, "R10 done held", done, 1);
    chk(err_pow == AW'(e_err) && sig_pow == AW'(e_sig), "R10 results held", err_pow, e_err);

    // R8: full-scale samples saturate the narrow instance only
    inv_ref_amp = CW'(1);
    sig_min = 0; sig_max = AW'(BIG); err_max = AW'(BIG);
    pulse_start;
    chk(err_pow == 0 && !done && !ovf, "R2 clear", err_pow, 0);
    for (int p = 0; p < 6 && !done; p++)
      for (int i = 0; i < N; i++) send(32767, 32767, i == 0);
    repeat (4) @(negedge clk);
    chk(done_s && ovf_s == 1, "R8 narrow saturates", ovf_s, 1);
    chk(pass_s == 0, "R8 R9 no pass on overflow", pass_s, 0);
    chk(ovf == 0, "R8 wide no overflow", ovf, 0);
    chk(dc_est == AW'(32767), "R4 full-scale dc", dc_est, 32767);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule